// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

This block collects up to eight edge-signalled interrupt requests, picks the most urgent one under a fixed priority order, raises a single interrupt line toward a processor, and on a one-cycle acknowledge returns an 8-bit vector that identifies the line. Software drives it through a small register port: one address bit, an 8-bit write bus and a combinational read bus.

Software must run a configuration sequence before any interrupt can be raised. The first command word is written at address 0. Three data words then follow at address 1: the vector base, a cascade word that is only stored, and a mode word that selects auto end-of-interrupt. Once configured, the block tracks pending requests, lines in service and a mask. Service ends with a specific end-of-interrupt command. Software can read back either the pending or the in-service set.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Writing 0x11 at address 0 starts configuration. The next three writes at address 1 load, in this order, the vector base, the cascade word (shown unchanged on `casc_cfg_o`) and the mode word.
- R2: The delivered vector is base[7:3] concatenated with the 3-bit line number, so the low three bits of the base word are ignored.
- R3: A rising edge on `irq_i[n]` sets pending bit n. A line held high after it is acknowledged does not set the bit again.
- R4: Outside configuration, a write at address 1 loads the mask (bit n = 1 masks line n), and a read at address 1 returns it. A masked line cannot raise `irq_o`, but its pending bit is still recorded.
- R5: Priority is fixed with line 0 highest. On acknowledge the winning line's pending bit is cleared and, unless auto end-of-interrupt is on, its in-service bit is set. The vector appears on `vec_o` in the same cycle.
- R6: `irq_o` is high only when configuration is complete and an unmasked pending line has a lower index than every in-service line.
- R7: Writing 0x60|n at address 0 clears in-service bit n.
- R8: A mode word with bit 1 set selects auto end-of-interrupt, in which an acknowledge sets no in-service bit.
- R9: An acknowledge while `irq_o` is low returns base[7:3] followed by 3'b111 and leaves the pending and in-service sets unchanged.
- R10: Writing 0x0A at address 0 makes reads at address 0 return the pending set. Writing 0x0B makes them return the in-service set. The choice holds until it is changed.
- R11: The configuration words do not alter the mask.
- R12: After reset the pending and in-service sets are clear, the mask is 0xFF, the pending set is selected for reads, `vec_o` is 0, and `irq_o` stays low until a configuration sequence completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 1 | Register address bit |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed register |
| irq_i | input | 8 | Request lines, rising edge sensitive |
| irq_o | output | 1 | Interrupt to processor |
| ack_i | input | 1 | One-cycle interrupt acknowledge |
| vec_o | output | 8 | Vector, valid while ack_i is high |
| casc_cfg_o | output | 8 | Stored cascade word |

## Verification
Directed patterns stack a lower-priority request behind one in service, to confirm it is held off, and then a higher-priority one, to confirm it preempts. End-of-interrupt commands are issued in both orders, which separates a controller that clears the named bit from one that clears the top bit. A line is held high through its acknowledge to show that a level is not mistaken for a new edge. Configuration is run with a base that has nonzero low bits and with auto end-of-interrupt on, an acknowledge is made with nothing pending, and a long random mix of pulses, masks, acknowledges and end-of-interrupt commands is checked against a reference model of pending, in-service and mask.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  typedef enum logic [2:0] {
    CFG_IDLE,
    CFG_BASE,
    CFG_CASC,
    CFG_MODE,
    CFG_RUN
  } cfg_state_e;

  localparam logic [7:0] CMD_INIT   = 8'h11;
  localparam logic [7:0] CMD_RD_REQ = 8'h0A;
  localparam logic [7:0] CMD_RD_SRV = 8'h0B;
  localparam logic [4:0] CMD_EOI_HI = 5'b01100;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_ctrl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              run_o,
  output logic              in_init_o,
  output logic [DATA_W-1:0] base_o,
  output logic [DATA_W-1:0] casc_o,
  output logic              aeoi_o,
  output logic [DATA_W-1:0] mask_o,
  output logic              rd_srv_o,
  output logic              eoi_vld_o,
  output logic [IDX_W-1:0]  eoi_idx_o
);
  cfg_state_e state_q;

  logic cmd_wr, data_wr;
  assign cmd_wr  = we_i && !addr_i;
  assign data_wr = we_i && addr_i;

  assign eoi_vld_o = cmd_wr && (wdata_i[DATA_W-1:IDX_W] == CMD_EOI_HI);
  assign eoi_idx_o = wdata_i[IDX_W-1:0];
  assign run_o     = (state_q == CFG_RUN);
  assign in_init_o = (state_q == CFG_BASE) || (state_q == CFG_CASC) || (state_q == CFG_MODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= CFG_IDLE;
      base_o   <= '0;
      casc_o   <= '0;
      aeoi_o   <= 1'b0;
      mask_o   <= '1;
      rd_srv_o <= 1'b0;
    end else begin
      if (cmd_wr) begin
        if (wdata_i == CMD_INIT)        state_q  <= CFG_BASE;
        else if (wdata_i == CMD_RD_REQ) rd_srv_o <= 1'b0;
        else if (wdata_i == CMD_RD_SRV) rd_srv_o <= 1'b1;
      end
      if (data_wr) begin
        unique case (state_q)
          CFG_BASE: begin base_o <= wdata_i; state_q <= CFG_CASC; end
          CFG_CASC: begin casc_o <= wdata_i; state_q <= CFG_MODE; end
          CFG_MODE: begin aeoi_o <= wdata_i[1]; state_q <= CFG_RUN; end
          default:  mask_o <= wdata_i;
        endcase
      end
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0] pend_i,
  input  logic [NUM_LINES-1:0] srv_i,
  output logic                 any_o,
  output logic [IDX_W-1:0]     win_o
);
  logic [NUM_LINES-1:0] above_srv;
  logic [NUM_LINES-1:0] elig;

  // bit n of above_srv: no in-service line at index <= n
  always_comb begin
    above_srv[0] = !srv_i[0];
    for (int i = 1; i < NUM_LINES; i++) above_srv[i] = above_srv[i-1] && !srv_i[i];
  end

  assign elig  = pend_i & above_srv;
  assign any_o = |elig;

  always_comb begin
    win_o = '0;
    for (int i = NUM_LINES-1; i >= 0; i--) begin
      if (elig[i]) win_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_req_track.sv
module irq_req_track #(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] lines_i,
  input  logic                 take_i,
  input  logic [IDX_W-1:0]     take_idx_i,
  input  logic                 aeoi_i,
  input  logic                 eoi_i,
  input  logic [IDX_W-1:0]     eoi_idx_i,
  output logic [NUM_LINES-1:0] irr_o,
  output logic [NUM_LINES-1:0] isr_o
);
  logic [NUM_LINES-1:0] prev_q, rise, irr_d, isr_d;

  assign rise = lines_i & ~prev_q;

  always_comb begin
    irr_d = irr_o;
    if (take_i) irr_d[take_idx_i] = 1'b0;
    irr_d = irr_d | rise;
    isr_d = isr_o;
    if (eoi_i) isr_d[eoi_idx_i] = 1'b0;
    if (take_i && !aeoi_i) isr_d[take_idx_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      irr_o  <= '0;
      isr_o  <= '0;
    end else begin
      prev_q <= lines_i;
      irr_o  <= irr_d;
      isr_o  <= isr_d;
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int NUM_LINES = 8,
  parameter int DATA_W    = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_we_i,
  input  logic                 bus_addr_i,
  input  logic [DATA_W-1:0]    bus_wdata_i,
  output logic [DATA_W-1:0]    bus_rdata_o,
  input  logic [NUM_LINES-1:0] irq_i,
  output logic                 irq_o,
  input  logic                 ack_i,
  output logic [DATA_W-1:0]    vec_o,
  output logic [DATA_W-1:0]    casc_cfg_o
);
  localparam int IDX_W = $clog2(NUM_LINES);

  logic              run, in_init, aeoi_q, rd_srv, eoi_vld, any_elig, take;
  logic [DATA_W-1:0] base_q, mask_q;
  logic [IDX_W-1:0]  eoi_idx, win;
  logic [NUM_LINES-1:0] irr_q, isr_q, pend;

  irq_cfg_regs #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_cfg (
    .clk_i, .rst_ni,
    .we_i(bus_we_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .run_o(run), .in_init_o(in_init), .base_o(base_q), .casc_o(casc_cfg_o),
    .aeoi_o(aeoi_q), .mask_o(mask_q), .rd_srv_o(rd_srv),
    .eoi_vld_o(eoi_vld), .eoi_idx_o(eoi_idx)
  );

  assign pend = irr_q & ~mask_q[NUM_LINES-1:0];

  irq_prio_pick #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) i_pick (
    .pend_i(pend), .srv_i(isr_q), .any_o(any_elig), .win_o(win)
  );

  assign irq_o = run && any_elig;
  assign take  = ack_i && irq_o;

  irq_req_track #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) i_track (
    .clk_i, .rst_ni, .lines_i(irq_i),
    .take_i(take), .take_idx_i(win), .aeoi_i(aeoi_q),
    .eoi_i(eoi_vld), .eoi_idx_i(eoi_idx),
    .irr_o(irr_q), .isr_o(isr_q)
  );

  always_comb begin
    vec_o = '0;
    if (ack_i) vec_o = {base_q[DATA_W-1:IDX_W], (irq_o ? win : {IDX_W{1'b1}})};
  end

  always_comb begin
    if (bus_addr_i)  bus_rdata_o = mask_q;
    else if (rd_srv) bus_rdata_o = DATA_W'(isr_q);
    else             bus_rdata_o = DATA_W'(irr_q);
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       we_i,
  input logic       addr_i,
  input logic       irq_o,
  input logic       ack_i,
  input logic [7:0] vec_o,
  input logic [7:0] irr,
  input logic [7:0] isr,
  input logic [7:0] mask,
  input logic       aeoi,
  input logic       run,
  input logic       in_init
);
  logic cmd_wr;
  assign cmd_wr = we_i && !addr_i;

  a_r12_quiet_until_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> !irq_o);

  a_r4_masked_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> |(irr & ~mask));

  a_r5_ack_marks_srv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o && !aeoi) |=> isr[$past(vec_o[2:0])]);

  a_r5_ack_drops_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o) |-> irr[vec_o[2:0]]);

  a_r8_aeoi_no_srv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && aeoi && !cmd_wr) |=> $stable(isr));

  a_r9_spurious_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !irq_o) |-> (vec_o[2:0] == 3'b111));

  a_r9_spurious_keeps_srv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !irq_o && !cmd_wr) |=> $stable(isr));

  a_r11_init_keeps_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i && in_init) |=> $stable(mask));
endmodule

bind irq_prio_ctrl irq_ctrl_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(bus_we_i), .addr_i(bus_addr_i),
  .irq_o(irq_o), .ack_i(ack_i), .vec_o(vec_o),
  .irr(irr_q), .isr(isr_q), .mask(mask_q), .aeoi(aeoi_q), .run(run), .in_init(in_init)
);

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, addr = 1'b0, ack = 1'b0;
  logic [7:0] wdata = '0, irq = '0;
  logic [7:0] rdata, vec, casc;
  logic irq_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_ctrl i_irq_prio_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_i(irq), .irq_o(irq_out),
    .ack_i(ack), .vec_o(vec), .casc_cfg_o(casc)
  );

  int total = 0, bad = 0;
  bit done = 1'b0;

  logic [7:0] m_irr = '0, m_isr = '0, m_mask = 8'hFF, m_base = '0, m_casc = '0;
  logic m_aeoi = 1'b0, m_sel = 1'b0, m_cfgd = 1'b0;
  int m_step = 0;

  function automatic bit m_run();
    return m_cfgd && (m_step == 0);
  endfunction

  function automatic int exp_win();
    int h = 8;
    for (int i = 7; i >= 0; i--) if (m_isr[i]) h = i;
    for (int i = 0; i < h; i++) if (m_irr[i] && !m_mask[i]) return i;
    return -1;
  endfunction

  function automatic logic exp_irq();
    return m_run() && (exp_win() >= 0);
  endfunction

  function automatic logic [7:0] exp_vec();
    int w = exp_win();
    if (m_run() && w >= 0) return {m_base[7:3], 3'(w)};
    return {m_base[7:3], 3'b111};
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic a, logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    if (!a) begin
      if (d == 8'h11) m_step = 1;
      else if (d == 8'h0A) m_sel = 1'b0;
      else if (d == 8'h0B) m_sel = 1'b1;
      else if (d[7:3] == 5'b01100) m_isr[d[2:0]] = 1'b0;
    end else begin
      case (m_step)
        1: begin m_base = d; m_step = 2; end
        2: begin m_casc = d; m_step = 3; end
        3: begin m_aeoi = d[1]; m_step = 0; m_cfgd = 1'b1; end
        default: m_mask = d;
      endcase
    end
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_chk(logic a, string tag);
    @(negedge clk); addr = a; #1;
    check(tag, rdata, a ? m_mask : (m_sel ? m_isr : m_irr));
  endtask

  task automatic pulse(logic [7:0] m);
    @(negedge clk); irq = m;
    @(posedge clk); m_irr |= m;
    @(negedge clk); irq = '0;
  endtask

  task automatic do_ack(string tag);
    int w;
    @(negedge clk); ack = 1'b1; #1;
    check(tag, vec, exp_vec());
    w = exp_win();
    @(posedge clk);
    if (m_run() && w >= 0) begin
      m_irr[w] = 1'b0;
      if (!m_aeoi) m_isr[w] = 1'b1;
    end
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic irq_chk(string tag);
    #1; check(tag, irq_out, exp_irq());
  endtask

  task automatic config_seq(logic [7:0] b, logic [7:0] c, logic [7:0] md);
    bus_wr(1'b0, 8'h11);
    bus_wr(1'b1, b);
    bus_wr(1'b1, c);
    bus_wr(1'b1, md);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check("R12 irq_o", irq_out, 0);
    check("R12 vec_o", vec, 0);
    rd_chk(1'b0, "R12 irr readback");
    rd_chk(1'b1, "R12 mask 0xFF");

    // R12: pending recorded but no interrupt before configuration
    pulse(8'h08);
    bus_wr(1'b1, 8'h00);
    irq_chk("R12 no irq before config");
    rd_chk(1'b0, "R12 pending visible");
    bus_wr(1'b1, 8'hFF);

    // R1 / R11 configuration
    config_seq(8'h20, 8'h04, 8'h01);
    check("R1 cascade stored", casc, 8'h04);
    rd_chk(1'b1, "R11 mask kept 0xFF");
    irq_chk("R4 masked no irq");
    bus_wr(1'b1, 8'h00);
    rd_chk(1'b1, "R4 mask readback");
    irq_chk("R4 unmasked irq");
    do_ack("R2 R5 vector line3");
    bus_wr(1'b0, 8'h0B);
    rd_chk(1'b0, "R10 isr readback");
    rd_chk(1'b0, "R10 selection persists");

    // R6 nesting
    pulse(8'h20);
    irq_chk("R6 lower prio held off");
    pulse(8'h02);
    irq_chk("R6 higher prio preempts");
    do_ack("R5 vector line1");
    rd_chk(1'b0, "R5 isr two lines");
    bus_wr(1'b0, 8'h61);
    rd_chk(1'b0, "R7 eoi line1");
    irq_chk("R6 still blocked by line3");
    bus_wr(1'b0, 8'h63);
    rd_chk(1'b0, "R7 eoi line3");
    irq_chk("R6 line5 released");
    do_ack("R5 vector line5");
    bus_wr(1'b0, 8'h65);

    // R9 spurious
    irq_chk("R9 idle");
    do_ack("R9 spurious vector");
    rd_chk(1'b0, "R9 isr unchanged");
    bus_wr(1'b0, 8'h0A);
    rd_chk(1'b0, "R10 irr selected");

    // R4 masked request retained
    bus_wr(1'b1, 8'h04);
    pulse(8'h04);
    irq_chk("R4 masked line silent");
    rd_chk(1'b0, "R4 masked request kept");
    bus_wr(1'b1, 8'h00);
    irq_chk("R4 unmask raises");
    do_ack("R5 vector line2");
    bus_wr(1'b0, 8'h62);

    // R3 level held through acknowledge
    @(negedge clk); irq = 8'h40;
    @(posedge clk); m_irr |= 8'h40;
    do_ack("R3 vector line6");
    bus_wr(1'b0, 8'h66);
    repeat (2) @(negedge clk);
    irq_chk("R3 held level no retrigger");
    rd_chk(1'b0, "R3 pending clear");
    @(negedge clk); irq = '0;

    // R8 auto-EOI, R2 low base bits ignored, R11 mask across reconfig
    bus_wr(1'b1, 8'h10);
    config_seq(8'h2B, 8'h02, 8'h03);
    check("R1 cascade id", casc, 8'h02);
    rd_chk(1'b1, "R11 mask unchanged");
    pulse(8'h20);
    pulse(8'h10);
    irq_chk("R4 line4 masked");
    bus_wr(1'b1, 8'h00);
    do_ack("R2 base low bits ignored");
    bus_wr(1'b0, 8'h0B);
    rd_chk(1'b0, "R8 no isr in auto mode");
    irq_chk("R8 next line raises");
    do_ack("R8 second vector");
    irq_chk("R8 idle");

    // random phase
    config_seq(8'h40, 8'h04, 8'h01);
    for (int n = 0; n < 400; n++) begin
      int r = int'($urandom % 6);
      case (r)
        0: pulse(8'($urandom) & 8'($urandom));
        1, 2: do_ack("R5 random ack");
        3: bus_wr(1'b0, {5'b01100, 3'($urandom)});
        4: bus_wr(1'b1, 8'($urandom) & 8'($urandom));
        default: begin
          bus_wr(1'b0, ($urandom % 2) ? 8'h0B : 8'h0A);
          rd_chk(1'b0, "R10 random readback");
          rd_chk(1'b1, "R4 random mask");
        end
      endcase
      irq_chk("R6 random irq");
    end
    finish_run();
  end
endmodule